// File: doc/BRIEF.md
# Indirect Scratchpad Register File

This block is a 64-byte register file for a small controller core. Most accesses go through a 6-bit pointer. The pointer is made of two 3-bit halves: a group number (upper half) and a cell-within-group index (lower half). Software can load either half or all six bits at once. The current pointer value is always visible at an output.

A single command can read or write the cell the pointer selects and, in the same cycle, step the pointer up or down by one. The step changes only the cell-within-group index, so a run of accesses wraps around inside one group of eight cells. A flag output goes high whenever the index is 7. A branch can use this flag to end a loop over one group.

The selected cell can also be decremented in place. The result is written back and appears on the read port. A direct mode ignores the pointer and reaches the lowest twelve cells through a 4-bit field; the core uses these cells as fixed save slots. The arithmetic unit and the status flags are outside this block.

Top module: `spm_regfile`

## Requirements
- R1: While reset is asserted and after it is released, `ptr` is 0, `lo_max` is 0 and `rdata` is 0. The content of the storage cells is left undefined by reset.
- R2: Command 1 loads `fld[2:0]` into `ptr[5:3]` and leaves `ptr[2:0]` unchanged. Command 2 loads `fld[2:0]` into `ptr[2:0]` and leaves `ptr[5:3]` unchanged. Both take effect at the next clock edge.
- R3: Command 3 loads `wdata[5:0]` into all six pointer bits at the next clock edge. The pointer value is always visible on `ptr`.
- R4: Command 4 (indirect read) sets `rdata`, at the next edge, to the cell addressed by the pointer value from before that edge.
- R5: Command 5 (indirect write) stores `wdata` into the cell addressed by the pointer value from before the edge, even when the same command steps the pointer.
- R6: For commands 4 and 5, `mode` value 1 adds one to `ptr[2:0]` modulo 8 and `mode` value 2 subtracts one modulo 8. `mode` values 0 and 3 leave the pointer unchanged. `ptr[5:3]` never changes by stepping, so octal 27 steps up to octal 20 and octal 20 steps down to octal 27.
- R7: Command 6 decrements the selected cell modulo 256 and writes the result back. `rdata` shows the new value at the next edge. The pointer does not change.
- R8: Command 7 (direct read) and command 8 (direct write) access cell `fld` for `fld` values 0 to 11, without using or changing the pointer.
- R9: With `fld` at 12 to 15, a direct write changes no cell and a direct read returns 0 on `rdata`.
- R10: `lo_max` is high exactly when `ptr[2:0]` equals 7.
- R11: Command 0 and the unused command codes 9 to 15 leave the pointer, `rdata` and every cell unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op | input | 4 | Command code (0 idle, 1 load group, 2 load index, 3 load full pointer, 4 indirect read, 5 indirect write, 6 decrement in place, 7 direct read, 8 direct write) |
| mode | input | 2 | Pointer step for commands 4 and 5 (0 keep, 1 up, 2 down, 3 keep) |
| fld | input | 4 | Direct cell number, or a pointer half value in bits 2:0 |
| wdata | input | 8 | Write data, and the full pointer value in bits 5:0 |
| rdata | output | 8 | Registered read result |
| ptr | output | 6 | Current pointer value |
| lo_max | output | 1 | High when the lower pointer half is 7 |

## Verification
On every cycle, the assertions check the pointer arithmetic. They check that half and full loads land in the right bits. They check that stepping leaves the group bits alone and moves the index by exactly one with wrap-around. They also check that the index-is-7 flag follows a load of 7, and that idle commands hold the pointer and the read data.

Storage effects can only be shown by scenarios that fill all 64 cells and read them back. Three effects need this: a write landing at the pre-step address, the wrap-around of the in-place decrement from 0 to 255, and an ignored direct write at fields 12 to 15 that leaves the underlying cell unchanged. The bench's reference model compares every output after every clock.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_SET_HI = 4'd1,
    OP_SET_LO = 4'd2,
    OP_SET_PT = 4'd3,
    OP_RD_IND = 4'd4,
    OP_WR_IND = 4'd5,
    OP_DEC    = 4'd6,
    OP_RD_DIR = 4'd7,
    OP_WR_DIR = 4'd8
  } spm_op_e;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_UP    = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_HOLD2 = 2'd3
  } spm_step_e;
endpackage

// File: rtl/spm_ptr.sv
module spm_ptr #(
  parameter int HALF_W = 3,
  localparam int PTR_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              ld_all,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic [HALF_W-1:0] half_val,
  input  logic [PTR_W-1:0]  full_val,
  output logic [PTR_W-1:0]  ptr_q
);
  logic [HALF_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic              en;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (ld_all) begin
      hi_d = full_val[PTR_W-1:HALF_W];
      lo_d = full_val[HALF_W-1:0];
    end else if (ld_hi) begin
      hi_d = half_val;
    end else if (ld_lo) begin
      lo_d = half_val;
    end else if (step_up) begin
      lo_d = lo_q + 1'b1;
    end else if (step_dn) begin
      lo_d = lo_q - 1'b1;
    end
  end

  assign en = ld_all | ld_hi | ld_lo | step_up | step_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign ptr_q = {hi_q, lo_q};
endmodule

// File: rtl/spm_array.sv
module spm_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wval,
  output logic [DATA_W-1:0] rval
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[addr] <= wval;
    end
  end

  assign rval = cells[addr];
endmodule

// File: rtl/spm_decode.sv
module spm_decode
  import spm_pkg::*;
#(
  parameter int DIR_W     = 4,
  parameter int DIR_CELLS = 12
) (
  input  logic [3:0]       op,
  input  logic [1:0]       mode,
  input  logic [DIR_W-1:0] fld,
  output logic             ld_hi,
  output logic             ld_lo,
  output logic             ld_all,
  output logic             rd_ind,
  output logic             wr_ind,
  output logic             dec_cell,
  output logic             rd_dir,
  output logic             wr_dir,
  output logic             dir_ok,
  output logic             step_up,
  output logic             step_dn
);
  spm_op_e   opc;
  spm_step_e stp;
  logic      ind_acc;

  assign opc = spm_op_e'(op);
  assign stp = spm_step_e'(mode);

  always_comb begin
    ld_hi    = 1'b0;
    ld_lo    = 1'b0;
    ld_all   = 1'b0;
    rd_ind   = 1'b0;
    wr_ind   = 1'b0;
    dec_cell = 1'b0;
    rd_dir   = 1'b0;
    wr_dir   = 1'b0;
    case (opc)
      OP_SET_HI: ld_hi    = 1'b1;
      OP_SET_LO: ld_lo    = 1'b1;
      OP_SET_PT: ld_all   = 1'b1;
      OP_RD_IND: rd_ind   = 1'b1;
      OP_WR_IND: wr_ind   = 1'b1;
      OP_DEC:    dec_cell = 1'b1;
      OP_RD_DIR: rd_dir   = 1'b1;
      OP_WR_DIR: wr_dir   = 1'b1;
      default:   ;
    endcase
  end

  assign ind_acc = rd_ind | wr_ind;
  assign step_up = ind_acc & (stp == STEP_UP);
  assign step_dn = ind_acc & (stp == STEP_DOWN);
  assign dir_ok  = (fld < DIR_W'(DIR_CELLS));
endmodule

// File: rtl/spm_regfile.sv
module spm_regfile #(
  parameter int DATA_W    = 8,
  parameter int HALF_W    = 3,
  parameter int DIR_W     = 4,
  parameter int DIR_CELLS = 12,
  localparam int PTR_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [1:0]        mode,
  input  logic [DIR_W-1:0]  fld,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PTR_W-1:0]  ptr,
  output logic              lo_max
);
  logic ld_hi, ld_lo, ld_all, rd_ind, wr_ind, dec_cell, rd_dir, wr_dir;
  logic dir_ok, step_up, step_dn;
  logic [PTR_W-1:0]  cell_addr, dir_cell;
  logic [DATA_W-1:0] cell_val, dec_val, wr_val, rdata_d, rdata_q;
  logic              we, rd_en;

  spm_decode #(.DIR_W(DIR_W), .DIR_CELLS(DIR_CELLS)) u_dec (
    .op(op), .mode(mode), .fld(fld),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_all(ld_all),
    .rd_ind(rd_ind), .wr_ind(wr_ind), .dec_cell(dec_cell),
    .rd_dir(rd_dir), .wr_dir(wr_dir), .dir_ok(dir_ok),
    .step_up(step_up), .step_dn(step_dn)
  );

  spm_ptr #(.HALF_W(HALF_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_all(ld_all),
    .step_up(step_up), .step_dn(step_dn),
    .half_val(fld[HALF_W-1:0]), .full_val(wdata[PTR_W-1:0]),
    .ptr_q(ptr)
  );

  generate
    if (PTR_W > DIR_W) begin : g_dir_pad
      assign dir_cell = {{(PTR_W-DIR_W){1'b0}}, fld};
    end else begin : g_dir_cut
      assign dir_cell = fld[PTR_W-1:0];
    end
  endgenerate

  assign cell_addr = (rd_dir | wr_dir) ? dir_cell : ptr;
  assign dec_val   = cell_val - 1'b1;
  assign wr_val    = dec_cell ? dec_val : wdata;
  assign we        = wr_ind | dec_cell | (wr_dir & dir_ok);

  spm_array #(.DATA_W(DATA_W), .ADDR_W(PTR_W)) u_arr (
    .clk(clk), .we(we), .addr(cell_addr), .wval(wr_val), .rval(cell_val)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd_ind)        rdata_d = cell_val;
    else if (dec_cell) rdata_d = dec_val;
    else if (rd_dir)   rdata_d = dir_ok ? cell_val : '0;
  end

  assign rd_en = rd_ind | dec_cell | rd_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata  = rdata_q;
  assign lo_max = &ptr[HALF_W-1:0];
endmodule

// File: rtl/spm_regfile_chk.sv
module spm_regfile_chk #(
  parameter int DATA_W = 8,
  parameter int HALF_W = 3,
  parameter int DIR_W  = 4,
  localparam int PTR_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op,
  input logic [1:0]        mode,
  input logic [DIR_W-1:0]  fld,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [PTR_W-1:0]  ptr,
  input logic              lo_max
);
  logic ind, idle;
  assign ind  = (op == 4'd4) || (op == 4'd5);
  assign idle = (op == 4'd0) || (op > 4'd8);

  p_load_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd1) |=> (ptr[PTR_W-1:HALF_W] == $past(fld[HALF_W-1:0]))
                     && (ptr[HALF_W-1:0] == $past(ptr[HALF_W-1:0])));

  p_load_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd2) |=> (ptr[HALF_W-1:0] == $past(fld[HALF_W-1:0]))
                     && (ptr[PTR_W-1:HALF_W] == $past(ptr[PTR_W-1:HALF_W])));

  p_load_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd3) |=> (ptr == $past(wdata[PTR_W-1:0])));

  p_group_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ind |=> $stable(ptr[PTR_W-1:HALF_W]));

  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ind && mode == 2'd1) |=> (ptr[HALF_W-1:0] == HALF_W'($past(ptr[HALF_W-1:0]) + 1'b1)));

  p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ind && mode == 2'd2) |=> (ptr[HALF_W-1:0] == HALF_W'($past(ptr[HALF_W-1:0]) - 1'b1)));

  p_dec_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd6) |=> $stable(ptr));

  p_dir_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7 || op == 4'd8) |=> $stable(ptr));

  p_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd2 && fld[HALF_W-1:0] == '1) |=> lo_max);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ($stable(ptr) && $stable(rdata)));
endmodule

bind spm_regfile spm_regfile_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W), .DIR_W(DIR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .mode(mode), .fld(fld), .wdata(wdata),
  .rdata(rdata), .ptr(ptr), .lo_max(lo_max)
);

// File: tb/spm_regfile_tb.sv
module spm_regfile_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] mode = '0;
  logic [3:0] fld = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] ptr;
  logic       lo_max;

  int n_chk = 0;
  int n_bad = 0;
  int m_ptr = 0;
  int m_rd  = 0;
  int m_mem [64];

  always #2 clk = ~clk;

  spm_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .mode(mode), .fld(fld),
    .wdata(wdata), .rdata(rdata), .ptr(ptr), .lo_max(lo_max)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "ptr", int'(ptr), m_ptr);
    chk(tag, "rdata", int'(rdata), m_rd);
    chk("R10", "lo_max", int'(lo_max), ((m_ptr % 8) == 7) ? 1 : 0);
  endtask

  task automatic step(input int o, input int m, input int f, input int d, input string tag);
    int a;
    int lo;
    op = 4'(o); mode = 2'(m); fld = 4'(f); wdata = 8'(d);
    @(posedge clk);
    a  = m_ptr;
    lo = m_ptr % 8;
    case (o)
      1: m_ptr = (f % 8) * 8 + lo;
      2: m_ptr = (m_ptr / 8) * 8 + (f % 8);
      3: m_ptr = d % 64;
      4, 5: begin
        if (o == 4) m_rd = m_mem[a];
        else        m_mem[a] = d;
        if (m == 1) m_ptr = (m_ptr / 8) * 8 + ((lo + 1) % 8);
        if (m == 2) m_ptr = (m_ptr / 8) * 8 + ((lo + 7) % 8);
      end
      6: begin
        m_mem[a] = (m_mem[a] + 255) % 256;
        m_rd = m_mem[a];
      end
      7: m_rd = (f < 12) ? m_mem[f] : 0;
      8: if (f < 12) m_mem[f] = d;
      default: ;
    endcase
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R3 full load, then R2 half loads and R5 writes with upward wrap (R6)
    step(3, 0, 0, 8'h2A, "R3");
    for (int g = 0; g < 8; g++) begin
      step(1, 0, g, 0, "R2");
      step(2, 0, 0, 0, "R2");
      for (int i = 0; i < 8; i++) step(5, 1, 0, (g * 29 + i * 7 + 3) % 256, "R5");
    end
    // R4 read-back of every cell, stepping up within each group
    for (int g = 0; g < 8; g++) begin
      step(1, 0, g, 0, "R2");
      for (int i = 0; i < 8; i++) step(4, 1, 0, 0, "R4");
    end
    // R6 wrap at octal 27 and 20
    step(3, 0, 0, 6'o27, "R3");
    step(4, 1, 0, 0, "R6");
    step(4, 2, 0, 0, "R6");
    step(4, 2, 0, 0, "R6");
    step(5, 2, 0, 8'h77, "R6");
    step(4, 3, 0, 0, "R6");
    step(2, 0, 7, 0, "R10");
    step(5, 3, 0, 8'h13, "R5");
    step(4, 0, 0, 0, "R5");
    // R7 decrement in place, including wrap through zero
    step(3, 0, 0, 5, "R3");
    step(5, 0, 0, 1, "R5");
    step(6, 0, 0, 0, "R7");
    step(6, 1, 0, 0, "R7");
    step(6, 0, 0, 0, "R7");
    step(4, 0, 0, 0, "R7");
    // R8 direct access, R9 fields out of range
    step(8, 0, 11, 8'hAB, "R8");
    step(7, 0, 11, 0, "R8");
    step(7, 0, 0, 0, "R8");
    step(8, 0, 13, 8'h55, "R9");
    step(7, 0, 13, 0, "R9");
    step(3, 0, 0, 13, "R3");
    step(4, 0, 0, 0, "R9");
    step(7, 0, 15, 0, "R9");
    // R11 idle and unused codes
    step(0, 1, 3, 8'hFF, "R11");
    step(9, 1, 3, 8'hFF, "R11");
    step(15, 2, 1, 8'h3F, "R11");
    step(12, 1, 5, 8'h01, "R11");
    step(4, 0, 0, 0, "R11");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule